// File: doc/BRIEF.md
# Stop-Mode Clock Gating Controller

This block governs the deepest standby state of a processor core. When the instruction decoder flags a stop instruction, the controller withdraws the core clock enable, parks the external bus port, and waits. It runs on a free-running clock that keeps ticking while the core clock is off. Only two asynchronous, active-low wake sources can end the wait: the core reset pin and one dedicated interrupt line. Both pass through a two-flop synchronizer before the state machine sees them.

A reset wake sends the core into reset processing through a one-cycle request. An interrupt wake starts a fixed wake-up delay. When the delay runs out, the controller either asks the core to serve the highest-priority pending interrupt and waits for that service to finish, or, if nothing is pending, resumes at once. Resumption is flagged by a one-cycle strobe. If the interrupt line is already low when the stop instruction arrives, the clock is never switched off and the delay starts immediately.

While the core is suspended, the bus strobes are held inactive, the data pins float and the address pins keep their last value. If bus grant was active when the stop instruction arrived, the whole port floats instead.

Top module: `stop_gate_ctrl`

## Requirements
- R1: A `stop_dec` pulse in run mode, with the synchronized interrupt line idle, drives `core_clk_en` low from the next cycle on, and it stays low until a wake.
- R2: While stopped, `stop_dec`, `pend_any`, `svc_done` and `bus_grant` have no effect; only a low `core_rst_n` or a low `irq_n` ends the stop.
- R3: A low `core_rst_n` during stop or wake delay raises `rst_req` for exactly one cycle, 3 cycles after the pin falls, with `core_clk_en` high again in that cycle and no `resume` or `svc_req`; `core_rst_n` is ignored in run mode.
- R4: When `core_rst_n` and `irq_n` fall in the same cycle during stop, the reset wake is taken and no interrupt service or resume follows.
- R5: An interrupt wake from a gated stop keeps `core_clk_en` low through a delay of `WAKE_DLY` cycles; the delay ends `WAKE_DLY + 3` cycles after `irq_n` falls.
- R6: If `pend_any` is high when the delay ends, `svc_req` pulses for one cycle with `core_clk_en` high, and `svc_is_wake` holds the value of `pend_top_is_wake` sampled in that cycle (1 = the top pending interrupt is the wake line), until service completes.
- R7: After `svc_req`, a `svc_done` pulse produces a `resume` pulse in the following cycle.
- R8: If `pend_any` is low when the delay ends, `resume` pulses in that cycle and `core_clk_en` returns high.
- R9: If the synchronized interrupt line is already low when `stop_dec` arrives, `core_clk_en` never drops, and `resume` pulses `WAKE_DLY + 1` cycles after `stop_dec`.
- R10: `bus_park` (strobes inactive high, data high impedance, address held) is high during stop and wake delay and low otherwise.
- R11: `bus_float` (whole port three-stated) is high during stop and delay only if `bus_grant` was high with `stop_dec`.
- R12: `resume`, `rst_req` and `svc_req` are single-cycle pulses, and all outputs are registered.
- R13: After reset `core_clk_en` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, active during stop |
| rst_n | input | 1 | Synchronous active-low block reset |
| stop_dec | input | 1 | One-cycle strobe: stop instruction decoded |
| core_rst_n | input | 1 | Asynchronous active-low core reset pin (wake source) |
| irq_n | input | 1 | Asynchronous active-low wake interrupt line |
| pend_any | input | 1 | At least one interrupt is pending |
| pend_top_is_wake | input | 1 | Highest-priority pending interrupt is the wake line |
| svc_done | input | 1 | Core finished serving the requested interrupt |
| bus_grant | input | 1 | External bus granted to another master |
| core_clk_en | output | 1 | Enable for the core clock gate |
| bus_park | output | 1 | Bus strobes inactive, data floating, address held |
| bus_float | output | 1 | Entire bus port three-stated |
| rst_req | output | 1 | One-cycle request to enter reset processing |
| svc_req | output | 1 | One-cycle request to serve the top pending interrupt |
| svc_is_wake | output | 1 | Served interrupt is the wake line |
| resume | output | 1 | One-cycle strobe: resume after the stop instruction |

## Verification
Every result has a fixed latency. The clock gate and bus controls move one cycle after `stop_dec`. A wake by pin is seen three cycles after the pin falls, because two cycles go to synchronization and one to the decision. The interrupt exit comes `WAKE_DLY + 3` cycles after `irq_n` falls, or `WAKE_DLY + 1` after `stop_dec` when the clock is never gated. The resume after service comes one cycle after `svc_done`. Each scenario drives its stimulus on a falling edge, counts rising edges while sampling on the next falling edge, and compares the cycle in which a pulse first appears with that count. It also checks that the pulse is gone one cycle later.

// File: rtl/sgc_pkg.sv
// Shared types for the stop-mode clock gating controller.
package sgc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,   // core running normally
        ST_STOP  = 2'd1,   // core suspended, waiting for a wake pin
        ST_DELAY = 2'd2,   // wake-up delay after an interrupt wake
        ST_SVC   = 2'd3    // core serving the top pending interrupt
    } sgc_state_t;
endpackage

// File: rtl/sgc_sync.sv
// Multi-stage synchronizer for asynchronous active-low pins.
// Output is active high (1 = pin asserted low). Assumes STAGES >= 2.
module sgc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] asserted
);
    logic [W-1:0] stage_q [STAGES];

    // first stage captures the inverted pin
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= ~pin_n;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // each further stage re-registers the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign asserted = stage_q[STAGES-1];

    // the last stage may only rise after the first stage had seen the pin (R2)
    assert_sync_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asserted[0]) |-> $past(stage_q[0][0]));
endmodule

// File: rtl/sgc_delay.sv
// Wake-up delay counter. While run is high it counts cycles; done is high
// in the last of DLY cycles. It clears whenever run is low. Assumes DLY >= 2.
module sgc_delay #(
    parameter int DLY = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (DLY > 2) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;

    // count while running, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

    // counter never passes the final delay value (R5)
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // done only follows a cycle in which the counter was running (R5)
    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != '0) |-> $past(run));
endmodule

// File: rtl/sgc_fsm.sv
// Stop-mode sequencer. It moves between run, stop, wake delay and service,
// and drives registered clock-enable, bus and request outputs.
// Assumes the wake inputs are already synchronized and active high.
module sgc_fsm
    import sgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_dec,
    input  logic rst_wake,
    input  logic irq_wake,
    input  logic dly_done,
    input  logic pend_any,
    input  logic pend_top_is_wake,
    input  logic svc_done,
    input  logic bus_grant,
    output logic dly_run,
    output logic core_clk_en,
    output logic bus_park,
    output logic bus_float,
    output logic rst_req,
    output logic svc_req,
    output logic svc_is_wake,
    output logic resume
);
    sgc_state_t state_q, state_d;
    logic gate_q, gate_d;
    logic float_q, float_d;
    logic clk_en_q, park_q;
    logic rst_q, svc_q, res_q, wake_sel_q;
    logic rst_hit, svc_hit, res_hit;

    // next-state and event decode
    always_comb begin
        state_d = state_q;
        gate_d  = gate_q;
        float_d = float_q;
        rst_hit = 1'b0;
        svc_hit = 1'b0;
        res_hit = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_dec) begin
                    float_d = bus_grant;
                    if (irq_wake) begin
                        state_d = ST_DELAY;
                        gate_d  = 1'b0;
                    end else begin
                        state_d = ST_STOP;
                        gate_d  = 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (rst_wake) begin
                    state_d = ST_RUN;
                    rst_hit = 1'b1;
                end else if (irq_wake) begin
                    state_d = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (rst_wake) begin
                    state_d = ST_RUN;
                    rst_hit = 1'b1;
                end else if (dly_done) begin
                    if (pend_any) begin
                        state_d = ST_SVC;
                        svc_hit = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                        res_hit = 1'b1;
                    end
                end
            end
            ST_SVC: begin
                if (svc_done) begin
                    state_d = ST_RUN;
                    res_hit = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
        if (state_d == ST_RUN || state_d == ST_SVC) begin
            gate_d  = 1'b0;
            float_d = 1'b0;
        end
    end

    // state and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            gate_q     <= 1'b0;
            float_q    <= 1'b0;
            clk_en_q   <= 1'b1;
            park_q     <= 1'b0;
            rst_q      <= 1'b0;
            svc_q      <= 1'b0;
            res_q      <= 1'b0;
            wake_sel_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            gate_q   <= gate_d;
            float_q  <= float_d;
            clk_en_q <= !gate_d;
            park_q   <= (state_d == ST_STOP) || (state_d == ST_DELAY);
            rst_q    <= rst_hit;
            svc_q    <= svc_hit;
            res_q    <= res_hit;
            if (svc_hit)                wake_sel_q <= pend_top_is_wake;
            else if (state_d != ST_SVC) wake_sel_q <= 1'b0;
        end
    end

    assign dly_run     = (state_q == ST_DELAY);
    assign core_clk_en = clk_en_q;
    assign bus_park    = park_q;
    assign bus_float   = float_q;
    assign rst_req     = rst_q;
    assign svc_req     = svc_q;
    assign svc_is_wake = wake_sel_q;
    assign resume      = res_q;

    // gated clock implies a parked bus (R1)
    assert_clk_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_q |-> park_q);
    // a reset wake never comes with service or resume (R4)
    assert_reset_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (!res_q && !svc_q));
    // resume only with the clock running (R7)
    assert_resume_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_q |-> clk_en_q);
    // full float only while parked (R11)
    assert_float_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
        float_q |-> park_q);
    // single-cycle pulses (R12)
    assert_resume_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_q |=> !res_q);
    assert_svc_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        svc_q |=> !svc_q);
    assert_rst_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);
endmodule

// File: rtl/stop_gate_ctrl.sv
// Top of the stop-mode clock gating controller. It synchronizes the two
// wake pins, times the wake delay and sequences stop entry and exit.
// Assumes clk is free-running and stays active while the core clock is gated.
module stop_gate_ctrl #(
    parameter int WAKE_DLY    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_dec,
    input  logic core_rst_n,
    input  logic irq_n,
    input  logic pend_any,
    input  logic pend_top_is_wake,
    input  logic svc_done,
    input  logic bus_grant,
    output logic core_clk_en,
    output logic bus_park,
    output logic bus_float,
    output logic rst_req,
    output logic svc_req,
    output logic svc_is_wake,
    output logic resume
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_asserted;
    logic            dly_run;
    logic            dly_done;

    sgc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    ({irq_n, core_rst_n}),
        .asserted (pin_asserted)
    );

    sgc_delay #(.DLY(WAKE_DLY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dly_run),
        .done  (dly_done)
    );

    sgc_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .stop_dec         (stop_dec),
        .rst_wake         (pin_asserted[0]),
        .irq_wake         (pin_asserted[1]),
        .dly_done         (dly_done),
        .pend_any         (pend_any),
        .pend_top_is_wake (pend_top_is_wake),
        .svc_done         (svc_done),
        .bus_grant        (bus_grant),
        .dly_run          (dly_run),
        .core_clk_en      (core_clk_en),
        .bus_park         (bus_park),
        .bus_float        (bus_float),
        .rst_req          (rst_req),
        .svc_req          (svc_req),
        .svc_is_wake      (svc_is_wake),
        .resume           (resume)
    );
endmodule

// File: tb/sim_stop_gate_ctrl.sv
// Directed bench for stop_gate_ctrl, one task per scenario.
module sim_stop_gate_ctrl;
    localparam int D = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_dec = 1'b0, core_rst_n = 1'b1, irq_n = 1'b1;
    logic pend_any = 1'b0, pend_top_is_wake = 1'b0, svc_done = 1'b0, bus_grant = 1'b0;
    logic core_clk_en, bus_park, bus_float, rst_req, svc_req, svc_is_wake, resume;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    stop_gate_ctrl #(.WAKE_DLY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_dec(stop_dec), .core_rst_n(core_rst_n),
        .irq_n(irq_n), .pend_any(pend_any), .pend_top_is_wake(pend_top_is_wake),
        .svc_done(svc_done), .bus_grant(bus_grant), .core_clk_en(core_clk_en),
        .bus_park(bus_park), .bus_float(bus_float), .rst_req(rst_req),
        .svc_req(svc_req), .svc_is_wake(svc_is_wake), .resume(resume)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // pulse stop_dec for one cycle; outputs sampled one cycle later
    task automatic do_stop(input logic grant);
        bus_grant = grant;
        stop_dec  = 1'b1;
        step(1);
        stop_dec  = 1'b0;
        bus_grant = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R13 clk_en", core_clk_en, 1);
        chk("R13 park", bus_park, 0);
        chk("R13 float", bus_float, 0);
        chk("R13 pulses", {rst_req, svc_req, resume, svc_is_wake}, 0);
    endtask

    // gated stop with grant, ignored inputs, then interrupt wake with nothing pending
    task automatic t_irq_wake_idle();
        int n = 0;
        int gated_ok = 1;
        do_stop(1'b1);
        chk("R1 clk_en low", core_clk_en, 0);
        chk("R10 park in stop", bus_park, 1);
        chk("R11 float with grant", bus_float, 1);
        for (int i = 0; i < 20; i++) begin
            stop_dec = i[0]; pend_any = 1'b1; svc_done = 1'b1; bus_grant = 1'b1;
            step(1);
            if (core_clk_en || resume || svc_req || rst_req || !bus_park) gated_ok = 0;
        end
        stop_dec = 1'b0; pend_any = 1'b0; svc_done = 1'b0; bus_grant = 1'b0;
        chk("R2 stop held against other inputs", gated_ok, 1);
        irq_n = 1'b0;
        gated_ok = 1;
        while (!resume && n < 1000) begin
            step(1); n++;
            if (!resume && core_clk_en) gated_ok = 0;
        end
        chk("R5 clock off during delay", gated_ok, 1);
        chk("R5 R8 resume latency", n, D + 3);
        chk("R8 clk_en at resume", core_clk_en, 1);
        chk("R10 park cleared", bus_park, 0);
        chk("R11 float cleared", bus_float, 0);
        step(1);
        chk("R12 resume single", resume, 0);
        irq_n = 1'b1;
        step(4);
    endtask

    // interrupt wake with a pending interrupt, then service handshake
    task automatic t_irq_wake_svc(input logic top_wake);
        int n = 0;
        pend_any = 1'b1;
        pend_top_is_wake = top_wake;
        do_stop(1'b0);
        chk("R11 no float without grant", bus_float, 0);
        irq_n = 1'b0;
        while (!svc_req && n < 1000) begin step(1); n++; end
        chk("R6 svc latency", n, D + 3);
        chk("R6 svc_is_wake", svc_is_wake, top_wake);
        chk("R6 clk_en at svc", core_clk_en, 1);
        chk("R6 no resume yet", resume, 0);
        irq_n = 1'b1;
        pend_any = 1'b0;
        pend_top_is_wake = ~top_wake;
        step(1);
        chk("R12 svc single", svc_req, 0);
        step(3);
        chk("R7 waits for done", resume, 0);
        chk("R6 svc_is_wake held", svc_is_wake, top_wake);
        svc_done = 1'b1;
        step(1);
        svc_done = 1'b0;
        chk("R7 resume after done", resume, 1);
        step(1);
        chk("R12 resume single after svc", resume, 0);
    endtask

    // reset pin wake, optionally together with the interrupt line
    task automatic t_rst_wake(input logic with_irq);
        int n = 0;
        int quiet = 1;
        do_stop(1'b0);
        core_rst_n = 1'b0;
        if (with_irq) irq_n = 1'b0;
        while (!rst_req && n < 100) begin step(1); n++; end
        chk(with_irq ? "R4 rst_req latency" : "R3 rst_req latency", n, 3);
        chk("R3 clk_en back", core_clk_en, 1);
        chk("R4 no resume with reset", resume | svc_req, 0);
        step(1);
        chk("R12 rst single", rst_req, 0);
        for (int i = 0; i < D + 6; i++) begin
            step(1);
            if (resume || svc_req || rst_req) quiet = 0;
        end
        chk("R3 R4 no later exit", quiet, 1);
        core_rst_n = 1'b1;
        irq_n = 1'b1;
        step(4);
    endtask

    // interrupt already asserted at stop: clock never gated
    task automatic t_no_gate();
        int n = 0;
        int on_ok = 1;
        int park_seen = 0;
        irq_n = 1'b0;
        step(4);
        do_stop(1'b0);
        n = 1;
        if (bus_park) park_seen = 1;
        while (!resume && n < 1000) begin
            if (!core_clk_en) on_ok = 0;
            step(1); n++;
            if (bus_park) park_seen = 1;
        end
        chk("R9 clock never gated", on_ok, 1);
        chk("R9 resume latency", n, D + 1);
        chk("R10 park during delay", park_seen, 1);
        irq_n = 1'b1;
        step(4);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset_state();
        t_irq_wake_idle();
        t_irq_wake_svc(1'b0);
        t_irq_wake_svc(1'b1);
        t_rst_wake(1'b0);
        t_rst_wake(1'b1);
        t_no_gate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule